// File: doc/BRIEF.md
# Keyed Watchdog Timer with Prescale Window

This block is a watchdog for a single clock domain. A free-running counter is compared against a 16-bit threshold. A 4-bit scale value selects which 16-bit slice of the counter goes to the comparator.

Every match sets a sticky interrupt flag. A match can also raise a system reset request, but only when that option is enabled. With the zero-on-match option set, the counter restarts after each match. This gives a periodic tick whose period does not depend on how quickly software services the flag.

All writes are guarded. A write only takes effect if the write just before it put the unlock key into the key register. Restarting the count is done by writing a fixed feed value into the feed register, so stray writes can neither reconfigure the timer nor keep it alive.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, the read values are: configuration 0, counter 0, compare 0xFFFF, key status 0. Both `irq_o` and `rst_req_o` are low.
- R2: While locked, writes to the configuration (address 0), counter (address 1), compare (address 5) and feed (address 3) registers change nothing.
- R3: Writing 0x5A17C0DE to the key register (address 4) unlocks exactly the next write. Any write to another address, including the read-only scaled view (address 2), locks again. The key register reads back 1 while unlocked.
- R4: The scaled view (address 2) reads counter bits [scale+15:scale], where scale is configuration bits [3:0].
- R5: With run-always (configuration bit 4) set, the counter rises by one every clock.
- R6: With only run-while-awake (configuration bit 5) set, the counter rises only in cycles where `core_awake_i` is high. With neither bit set, the counter holds.
- R7: An unlocked write of 0xFEED0042 to the feed register clears the counter. Any other value written there is ignored, and so is a locked write of the feed value.
- R8: When the scaled count is greater than or equal to the compare value, the pending flag (configuration bit 8, mirrored on `irq_o`) is set on the next edge. It stays set until an unlocked configuration write with bit 8 low, made while no match is present.
- R9: With zero-on-match (configuration bit 6) set, a match clears the counter on the next edge.
- R10: `rst_req_o` goes high on the edge after a match only when reset-enable (configuration bit 7) is set. It drops on the edge after the match ends.
- R11: Writing any value other than the unlock key into the key register leaves the block locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| core_awake_i | input | 1 | High while the processor is running |
| irq_o | output | 1 | Sticky match interrupt |
| rst_req_o | output | 1 | System reset request |

## Verification
The hardest state to reach from the ports is a match at an exactly known cycle with a chosen scale. With a free-running counter, that needs long and timing-sensitive waits. The stimulus avoids this by stopping the counter and loading it through an unlocked counter write, placing it exactly on the compare value. The interrupt, zero-on-match and reset-request responses are then sampled in the first and second cycles after the load edge. The one-shot lock is driven by a vector table that mixes locked writes, wrong keys and writes to the read-only view, each followed by a read-back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SCALE_W = 4;

  typedef enum logic [2:0] {
    A_CFG    = 3'd0,
    A_CNT    = 3'd1,
    A_SCALED = 3'd2,
    A_FEED   = 3'd3,
    A_KEY    = 3'd4,
    A_CMP    = 3'd5
  } wdt_addr_e;

  typedef struct packed {
    logic               rst_en;
    logic               zero_on_match;
    logic               run_awake;
    logic               run_always;
    logic [SCALE_W-1:0] scale;
  } wdt_cfg_t;

  localparam int CFG_W   = $bits(wdt_cfg_t);
  localparam int PEND_BIT = CFG_W;
endpackage

// File: rtl/wdt_key_gate.sv
module wdt_key_gate #(
  parameter int          DATA_W  = 32,
  parameter logic [DATA_W-1:0] KEY_VAL = 32'h5A17_C0DE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              unlocked_o,
  output logic              wr_ok_o
);
  import wdt_pkg::*;

  logic unlocked_q, unlocked_d;
  logic is_key;

  assign is_key = (addr_i == A_KEY);

  // any write consumes the key; only a matching key write re-arms it
  always_comb begin
    unlocked_d = unlocked_q;
    if (we_i) unlocked_d = is_key && (wdata_i == KEY_VAL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) unlocked_q <= 1'b0;
    else         unlocked_q <= unlocked_d;
  end

  assign unlocked_o = unlocked_q;
  assign wr_ok_o    = we_i && unlocked_q && !is_key;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 31,
  parameter int CMP_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        run_i,
  input  logic                        zero_i,
  input  logic                        load_i,
  input  logic [CNT_W-1:0]            load_val_i,
  input  logic [wdt_pkg::SCALE_W-1:0] scale_i,
  output logic [CNT_W-1:0]            cnt_o,
  output logic [CMP_W-1:0]            scaled_o
);
  import wdt_pkg::*;

  localparam int NWIN = 2 ** SCALE_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CMP_W-1:0] win [NWIN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (zero_i) cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  // one window per scale tap; taps past the counter top fill with zeros
  for (genvar s = 0; s < NWIN; s++) begin : g_win
    if (s + CMP_W <= CNT_W) begin : g_full
      assign win[s] = cnt_q[s +: CMP_W];
    end else begin : g_part
      assign win[s] = CMP_W'(cnt_q >> s);
    end
  end

  assign scaled_o = win[scale_i];
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/wdt_cmp.sv
module wdt_cmp #(
  parameter int CMP_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMP_W-1:0] scaled_i,
  input  logic [CMP_W-1:0] cmp_i,
  input  logic             rst_en_i,
  input  logic             pend_we_i,
  input  logic             pend_wd_i,
  output logic             hit_o,
  output logic             pend_o,
  output logic             rst_req_o
);
  logic pend_q, rst_q;

  assign hit_o = (scaled_i >= cmp_i);

  // a live match wins over a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      pend_q <= hit_o | (pend_we_i ? pend_wd_i : pend_q);
      rst_q  <= hit_o & rst_en_i;
    end
  end

  assign pend_o    = pend_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int                DATA_W   = 32,
  parameter int                CNT_W    = 31,
  parameter int                CMP_W    = 16,
  parameter logic [DATA_W-1:0] KEY_VAL  = 32'h5A17_C0DE,
  parameter logic [DATA_W-1:0] FEED_VAL = 32'hFEED_0042
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              core_awake_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  import wdt_pkg::*;

  localparam logic [CMP_W-1:0] CMP_RST = '1;

  wdt_cfg_t         cfg_q;
  logic [CMP_W-1:0] cmp_q;
  logic             unlocked, wr_ok;
  logic             hit, pend, run;
  logic             load;
  logic [CNT_W-1:0] load_val, cnt;
  logic [CMP_W-1:0] scaled;
  logic             cfg_wr, cmp_wr;

  wdt_key_gate #(.DATA_W(DATA_W), .KEY_VAL(KEY_VAL)) u_key (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .unlocked_o (unlocked),
    .wr_ok_o    (wr_ok)
  );

  assign cfg_wr = wr_ok && (reg_addr_i == A_CFG);
  assign cmp_wr = wr_ok && (reg_addr_i == A_CMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      cmp_q <= CMP_RST;
    end else begin
      if (cfg_wr) cfg_q <= wdt_cfg_t'(reg_wdata_i[CFG_W-1:0]);
      if (cmp_wr) cmp_q <= reg_wdata_i[CMP_W-1:0];
    end
  end

  assign run  = cfg_q.run_always | (cfg_q.run_awake & core_awake_i);
  assign load = wr_ok && ((reg_addr_i == A_CNT) ||
                          ((reg_addr_i == A_FEED) && (reg_wdata_i == FEED_VAL)));
  assign load_val = (reg_addr_i == A_CNT) ? reg_wdata_i[CNT_W-1:0] : '0;

  wdt_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_cnt (
    .clk_i, .rst_ni,
    .run_i      (run),
    .zero_i     (hit & cfg_q.zero_on_match),
    .load_i     (load),
    .load_val_i (load_val),
    .scale_i    (cfg_q.scale),
    .cnt_o      (cnt),
    .scaled_o   (scaled)
  );

  wdt_cmp #(.CMP_W(CMP_W)) u_cmp (
    .clk_i, .rst_ni,
    .scaled_i  (scaled),
    .cmp_i     (cmp_q),
    .rst_en_i  (cfg_q.rst_en),
    .pend_we_i (cfg_wr),
    .pend_wd_i (reg_wdata_i[PEND_BIT]),
    .hit_o     (hit),
    .pend_o    (pend),
    .rst_req_o (rst_req_o)
  );

  assign irq_o = pend;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      A_CFG:    reg_rdata_o = DATA_W'({pend, cfg_q});
      A_CNT:    reg_rdata_o = DATA_W'(cnt);
      A_SCALED: reg_rdata_o = DATA_W'(scaled);
      A_KEY:    reg_rdata_o = DATA_W'(unlocked);
      A_CMP:    reg_rdata_o = DATA_W'(cmp_q);
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk #(
  parameter int CNT_W = 31,
  parameter int CMP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [2:0]       reg_addr_i,
  input logic             unlocked,
  input logic             wr_ok,
  input logic             hit,
  input logic             run,
  input logic             rst_en,
  input logic             zero_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CMP_W-1:0] cmp_q,
  input logic             irq_o,
  input logic             rst_req_o
);
  // R3: one write consumes the unlock
  a_r3_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && (reg_addr_i != 3'd4) |=> !unlocked);

  // R2: compare holds while locked
  a_r2_cmp_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked |=> $stable(cmp_q));

  // R8: pending flag only drops through a permitted write
  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !wr_ok |=> irq_o);

  // R10: reset request needs a match with reset enabled
  a_r10_rst_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(hit) && $past(rst_en));

  // R9: match with zero-on-match restarts the count
  a_r9_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit && zero_en && !wr_ok |=> cnt == '0);

  // R6: idle counter holds
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run && !hit && !wr_ok |=> $stable(cnt));
endmodule

bind keyed_wdt keyed_wdt_chk #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .unlocked   (unlocked),
  .wr_ok      (wr_ok),
  .hit        (hit),
  .run        (run),
  .rst_en     (cfg_q.rst_en),
  .zero_en    (cfg_q.zero_on_match),
  .cnt        (cnt),
  .cmp_q      (cmp_q),
  .irq_o      (irq_o),
  .rst_req_o  (rst_req_o)
);

// File: tb/keyed_wdt_tb.sv
module keyed_wdt_tb;
  localparam logic [31:0] KEY  = 32'h5A17_C0DE;
  localparam logic [31:0] FEED = 32'hFEED_0042;
  localparam logic [2:0] CFG = 3'd0, CNT = 3'd1, SCL = 3'd2, FD = 3'd3, KY = 3'd4, CMP = 3'd5;

  typedef struct packed {
    logic        unl;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [2:0]  ra;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, CMP, 32'h0000_1111, CMP, 32'h0000_FFFF, 4'd2},  // R2 locked compare write
    '{1'b1, CMP, 32'h0000_FFF0, CMP, 32'h0000_FFF0, 4'd3},  // R3 unlocked write lands
    '{1'b0, CMP, 32'h0000_0030, CMP, 32'h0000_FFF0, 4'd3},  // R3 second write blocked
    '{1'b1, CNT, 32'h0000_1230, CNT, 32'h0000_1230, 4'd4},  // R4 load counter
    '{1'b1, CFG, 32'h0000_0004, SCL, 32'h0000_0123, 4'd4},  // R4 scale 4
    '{1'b1, CFG, 32'h0000_0000, SCL, 32'h0000_1230, 4'd4},  // R4 scale 0
    '{1'b0, CFG, 32'h0000_0010, CFG, 32'h0000_0000, 4'd2},  // R2 locked config write
    '{1'b0, KY,  32'h0000_DEAD, KY,  32'h0000_0000, 4'd11}, // R11 wrong key
    '{1'b1, SCL, 32'h0000_0005, KY,  32'h0000_0000, 4'd3}   // R3 read-only write consumes key
  };

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0, awake = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq, rreq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  keyed_wdt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .core_awake_i(awake),
    .irq_o(irq), .rst_req_o(rreq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic unlock();
    wr(KY, KEY);
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(CFG, a); chk("R1 cfg", a, 32'h0);
    rd(CNT, a); chk("R1 cnt", a, 32'h0);
    rd(CMP, a); chk("R1 cmp", a, 32'h0000_FFFF);
    rd(KY, a);  chk("R1 key", a, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 rst_req", 32'(rreq), 32'h0);

    foreach (VECS[i]) begin
      if (VECS[i].unl) unlock();
      wr(VECS[i].wa, VECS[i].wd);
      rd(VECS[i].ra, a);
      chk($sformatf("R%0d vec %0d", VECS[i].req, i), a, VECS[i].exp);
    end

    // R5 free run
    unlock(); wr(CFG, 32'h10);
    rd(CNT, a); repeat (10) @(negedge clk); rd(CNT, b);
    chk("R5 run_always delta", b - a, 32'd10);

    // R6 awake gating
    unlock(); wr(CFG, 32'h20);
    rd(CNT, a); repeat (10) @(negedge clk); rd(CNT, b);
    chk("R6 asleep hold", b - a, 32'd0);
    awake = 1'b1;
    rd(CNT, a); repeat (10) @(negedge clk); rd(CNT, b);
    chk("R6 awake delta", b - a, 32'd10);
    awake = 1'b0;
    unlock(); wr(CFG, 32'h0);
    rd(CNT, a); repeat (5) @(negedge clk); rd(CNT, b);
    chk("R6 disabled hold", b - a, 32'd0);

    // R7 feed
    unlock(); wr(CNT, 32'h55);
    unlock(); wr(FD, 32'h1234);
    rd(CNT, a); chk("R7 wrong feed ignored", a, 32'h55);
    wr(FD, FEED);
    rd(CNT, a); chk("R7 locked feed ignored", a, 32'h55);
    unlock(); wr(FD, FEED);
    rd(CNT, a); chk("R7 feed clears", a, 32'h0);

    // R8 sticky pending
    unlock(); wr(CMP, 32'h10);
    unlock(); wr(CNT, 32'h10);
    chk("R8 irq not yet", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R8 irq set", 32'(irq), 32'h1);
    chk("R10 no rst_req when disabled", 32'(rreq), 32'h0);
    rd(CFG, a); chk("R8 pend bit", a, 32'h100);
    unlock(); wr(CNT, 32'h0);
    @(negedge clk);
    chk("R8 sticky", 32'(irq), 32'h1);
    unlock(); wr(CFG, 32'h0);
    chk("R8 cleared", 32'(irq), 32'h0);

    // R10 reset request
    unlock(); wr(CFG, 32'h80);
    unlock(); wr(CNT, 32'h10);
    chk("R10 rst_req not yet", 32'(rreq), 32'h0);
    @(negedge clk);
    chk("R10 rst_req set", 32'(rreq), 32'h1);
    unlock(); wr(CNT, 32'h0);
    chk("R10 rst_req lag", 32'(rreq), 32'h1);
    @(negedge clk);
    chk("R10 rst_req drops", 32'(rreq), 32'h0);
    unlock(); wr(CFG, 32'h0);

    // R9 zero on match
    unlock(); wr(CFG, 32'h40);
    unlock(); wr(CNT, 32'h10);
    rd(CNT, a); chk("R9 loaded", a, 32'h10);
    @(negedge clk);
    rd(CNT, a); chk("R9 zeroed", a, 32'h0);
    chk("R9 irq", 32'(irq), 32'h1);
    unlock(); wr(CFG, 32'h0);

    // R4 top tap
    unlock(); wr(CNT, 32'h7FFF_8000);
    unlock(); wr(CFG, 32'hF);
    rd(SCL, a); chk("R4 scale 15", a, 32'h0000_FFFF);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule